// File: doc/BRIEF.md
# System control register block: soft resets and clock gates

This block is a small bank of memory-mapped control registers on a plain 32-bit register bus. A request is presented for one cycle with an address, a write flag and write data. The block answers one cycle later with a ready pulse and, for reads, the register value. It turns register bits into level outputs for the rest of the chip: per-peripheral reset lines, leaf clock-run enables, a PCI clock-run enable, a security clock ratio select, a TV clock half-divider value and a PCI speed select. It also shows strap inputs through a read-only status word.

Resets are self-timed. Writing a 1 to a bit of the soft-reset register raises that line's reset output for a fixed number of cycles. The line then drops again without any further write. While the pulse is running, the bit reads back as 1. One line, the second processor's reset at bit 30, is added to every soft-reset write. Clock gates use stop-on-one polarity, so a freshly reset block leaves every leaf clock running. The gate bit for the DDR controller can never be set.

Top module: `sysctl_regs`

## Requirements
- R1: A synchronous active-high reset clears all control state. After reset, every leaf clock runs, no reset line is raised, the PCI clock-run enable, security select, TV divider and PCI speed outputs are 0, and ready and read data are 0.
- R2: Every cycle with a request is answered by ready high in the next cycle. Ready is low in the cycle after a cycle without a request.
- R3: A write to offset 0x0C starts a pulse on each reset line whose data bit is 1. The line is high for exactly PULSE_LEN (default 16) cycles, starting the cycle after the write, and then falls by itself.
- R4: Every write to offset 0x0C also starts a pulse on line 30, even when data bit 30 is 0.
- R5: A new write to a line whose pulse is still running reloads its count, so the line stays high for PULSE_LEN cycles after the later write.
- R6: A read of offset 0x0C returns 1 in each bit whose reset pulse is running at the time of the request.
- R7: In the clock-control register at offset 0x34, bits 1 to 13 stop the leaf clocks: output leaf_run[k] is the inverse of bit k+1, so 1 stops the clock and 0 runs it.
- R8: Bit 10 of clock control (the DDR controller's gate) ignores writes and always reads 0, so leaf_run[9] stays 1.
- R9: Clock-control bit 16 drives pci_clkrun_en. Bit 29 drives sec_clk_full (1 = full rate, 0 = three quarters). Bits 28:24 drive tv_half_div. All three read back at the same positions.
- R10: Bit 18 of the miscellaneous register at offset 0x30 drives pci_fast (1 = 66 MHz, 0 = 33 MHz) and reads back at bit 18.
- R11: Offset 0x04 is read-only. Bit 30 returns strap_xtal_sel, bits 19:18 return strap_cpu_ratio and bits 17:15 return strap_ahb_speed. Writes to it change nothing.
- R12: Bits not named above read as 0 and ignore writes. Any other address reads 0, and a write to it changes no output or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready (0 after writes) |
| bus_ready | output | 1 | Response, one cycle after the request |
| strap_xtal_sel | input | 1 | Crystal select strap |
| strap_ahb_speed | input | 3 | Bus speed strap |
| strap_cpu_ratio | input | 2 | Processor-to-bus ratio strap |
| periph_rst | output | NUM_RST | Per-peripheral reset lines, active high |
| leaf_run | output | GATE_HI-GATE_LO+1 | Leaf clock enables, 1 = running |
| pci_clkrun_en | output | 1 | PCI clock-run enable |
| sec_clk_full | output | 1 | Security clock ratio select |
| tv_half_div | output | 5 | TV clock half-divider value |
| pci_fast | output | 1 | PCI speed select |

## Verification
The properties take for granted that the address, write flag and write data are known in every cycle that carries a request. They also assume the requester never stalls, because the block has no backpressure and answers every request exactly one cycle later. Straps are treated as slow levels that only matter at the edge where a status read is taken.

The stimulus drives every input at the falling edge, so each value is stable across the sampling edge. It changes straps only between requests, sends back-to-back requests, and never leaves an address undriven while a request is high.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int unsigned DATA_W = 32;

   // register byte offsets
   localparam logic [7:0] OFS_STATUS = 8'h04;
   localparam logic [7:0] OFS_SRST   = 8'h0C;
   localparam logic [7:0] OFS_MISC   = 8'h30;
   localparam logic [7:0] OFS_CLK    = 8'h34;

   // status word field positions
   localparam int unsigned ST_XTAL_BIT  = 30;
   localparam int unsigned ST_RATIO_LSB = 18;
   localparam int unsigned ST_SPEED_LSB = 15;

   // clock-control field positions
   localparam int unsigned CK_CLKRUN_BIT = 16;
   localparam int unsigned CK_TVDIV_LSB  = 24;
   localparam int unsigned CK_TVDIV_W    = 5;
   localparam int unsigned CK_SECSEL_BIT = 29;

   // miscellaneous field position
   localparam int unsigned MS_PCIFAST_BIT = 18;

   typedef struct packed {
      logic status;
      logic srst;
      logic misc;
      logic clk;
   } sel_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_t              sel
);

   always_comb begin
      sel        = '0;
      sel.status = (addr == ADDR_W'(OFS_STATUS));
      sel.srst   = (addr == ADDR_W'(OFS_SRST));
      sel.misc   = (addr == ADDR_W'(OFS_MISC));
      sel.clk    = (addr == ADDR_W'(OFS_CLK));
   end

endmodule

// File: rtl/sysctl_srst.sv
module sysctl_srst #(
   parameter int unsigned NUM_RST   = 32,
   parameter int unsigned PULSE_LEN = 16,
   parameter int unsigned FORCE_BIT = 30
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr,
   input  logic [NUM_RST-1:0] wbits,
   output logic [NUM_RST-1:0] active
);

   localparam int unsigned       CNT_W      = $clog2(PULSE_LEN + 1);
   localparam logic [CNT_W-1:0]  LOAD       = CNT_W'(PULSE_LEN);
   localparam logic [NUM_RST-1:0] FORCE_MSK = NUM_RST'(1) << FORCE_BIT;

   logic [NUM_RST-1:0] start;
   assign start = wr ? (wbits | FORCE_MSK) : '0;

   for (genvar g = 0; g < NUM_RST; g++) begin : g_line
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (rst)
            cnt <= '0;
         else if (start[g])
            cnt <= LOAD;
         else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
      end
      assign active[g] = (cnt != '0);
   end

endmodule

// File: rtl/sysctl_clkreg.sv
module sysctl_clkreg
   import sysctl_pkg::*;
#(
   parameter int unsigned GATE_LO  = 1,
   parameter int unsigned GATE_HI  = 13,
   parameter int unsigned DDR_GATE = 10
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         wr_clk,
   input  logic                         wr_misc,
   input  logic [DATA_W-1:0]            wdata,
   output logic [DATA_W-1:0]            rd_clk,
   output logic [DATA_W-1:0]            rd_misc,
   output logic [GATE_HI-GATE_LO:0]     gate_stop,
   output logic                         clkrun,
   output logic                         secsel,
   output logic [CK_TVDIV_W-1:0]        tvdiv,
   output logic                         pcifast
);

   function automatic logic [DATA_W-1:0] clk_mask_f();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = GATE_LO; i <= GATE_HI; i++)
         if (i != DDR_GATE) m[i] = 1'b1;
      m[CK_CLKRUN_BIT] = 1'b1;
      m[CK_SECSEL_BIT] = 1'b1;
      for (int i = 0; i < CK_TVDIV_W; i++)
         m[CK_TVDIV_LSB+i] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] CLK_MASK  = clk_mask_f();
   localparam logic [DATA_W-1:0] MISC_MASK = DATA_W'(1) << MS_PCIFAST_BIT;

   logic [DATA_W-1:0] clk_q;
   logic [DATA_W-1:0] misc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         clk_q  <= '0;
         misc_q <= '0;
      end else begin
         if (wr_clk)  clk_q  <= wdata & CLK_MASK;
         if (wr_misc) misc_q <= wdata & MISC_MASK;
      end
   end

   assign rd_clk    = clk_q;
   assign rd_misc   = misc_q;
   assign gate_stop = clk_q[GATE_HI:GATE_LO];
   assign clkrun    = clk_q[CK_CLKRUN_BIT];
   assign secsel    = clk_q[CK_SECSEL_BIT];
   assign tvdiv     = clk_q[CK_TVDIV_LSB +: CK_TVDIV_W];
   assign pcifast   = misc_q[MS_PCIFAST_BIT];

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned NUM_RST       = 32,
   parameter int unsigned PULSE_LEN     = 16,
   parameter int unsigned FORCE_RST_BIT = 30,
   parameter int unsigned GATE_LO       = 1,
   parameter int unsigned GATE_HI       = 13,
   parameter int unsigned DDR_GATE      = 10
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     bus_req,
   input  logic                     bus_we,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   output logic                     bus_ready,
   input  logic                     strap_xtal_sel,
   input  logic [2:0]               strap_ahb_speed,
   input  logic [1:0]               strap_cpu_ratio,
   output logic [NUM_RST-1:0]       periph_rst,
   output logic [GATE_HI-GATE_LO:0] leaf_run,
   output logic                     pci_clkrun_en,
   output logic                     sec_clk_full,
   output logic [4:0]               tv_half_div,
   output logic                     pci_fast
);

   localparam int unsigned NUM_GATES = GATE_HI - GATE_LO + 1;

   // elaboration-time parameter checks
   if (ADDR_W < 6)
      $error("ADDR_W must reach offset 0x34");
   if (NUM_RST < 1 || NUM_RST > DATA_W)
      $error("NUM_RST must be 1..32");
   if (FORCE_RST_BIT >= NUM_RST)
      $error("FORCE_RST_BIT must lie inside the reset lines");
   if (PULSE_LEN < 1)
      $error("PULSE_LEN must be at least 1");
   if (GATE_LO < 1 || GATE_HI < GATE_LO || GATE_HI >= CK_CLKRUN_BIT)
      $error("gate field must sit within bits 1..15");
   if (DDR_GATE <= GATE_LO || DDR_GATE > GATE_HI)
      $error("DDR_GATE must be a gate bit above GATE_LO");

   sel_t sel;
   sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   logic wr_any;
   assign wr_any = bus_req & bus_we;

   logic [NUM_RST-1:0] srst_active;
   sysctl_srst #(
      .NUM_RST   (NUM_RST),
      .PULSE_LEN (PULSE_LEN),
      .FORCE_BIT (FORCE_RST_BIT)
   ) u_srst (
      .clk    (clk),
      .rst    (rst),
      .wr     (wr_any & sel.srst),
      .wbits  (bus_wdata[NUM_RST-1:0]),
      .active (srst_active)
   );

   logic [DATA_W-1:0]     rd_clk, rd_misc;
   logic [NUM_GATES-1:0]  gate_stop;
   sysctl_clkreg #(
      .GATE_LO  (GATE_LO),
      .GATE_HI  (GATE_HI),
      .DDR_GATE (DDR_GATE)
   ) u_clk (
      .clk       (clk),
      .rst       (rst),
      .wr_clk    (wr_any & sel.clk),
      .wr_misc   (wr_any & sel.misc),
      .wdata     (bus_wdata),
      .rd_clk    (rd_clk),
      .rd_misc   (rd_misc),
      .gate_stop (gate_stop),
      .clkrun    (pci_clkrun_en),
      .secsel    (sec_clk_full),
      .tvdiv     (tv_half_div),
      .pcifast   (pci_fast)
   );

   // read-only status word
   logic [DATA_W-1:0] status_w;
   always_comb begin
      status_w = '0;
      status_w[ST_XTAL_BIT]       = strap_xtal_sel;
      status_w[ST_RATIO_LSB +: 2] = strap_cpu_ratio;
      status_w[ST_SPEED_LSB +: 3] = strap_ahb_speed;
   end

   logic [DATA_W-1:0] rd_val;
   always_comb begin
      unique case (1'b1)
         sel.status: rd_val = status_w;
         sel.srst:   rd_val = DATA_W'(srst_active);
         sel.misc:   rd_val = rd_misc;
         sel.clk:    rd_val = rd_clk;
         default:    rd_val = '0;
      endcase
   end

   logic [DATA_W-1:0] rdata_q;
   logic              ready_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         rdata_q <= '0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= bus_req;
         rdata_q <= (bus_req && !bus_we) ? rd_val : '0;
      end
   end

   assign bus_rdata  = rdata_q;
   assign bus_ready  = ready_q;
   assign periph_rst = srst_active;

   for (genvar k = 0; k < NUM_GATES; k++) begin : g_leaf
      assign leaf_run[k] = ~gate_stop[k];
   end

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
   import sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned NUM_RST       = 32,
   parameter int unsigned FORCE_RST_BIT = 30,
   parameter int unsigned GATE_LO       = 1,
   parameter int unsigned GATE_HI       = 13,
   parameter int unsigned DDR_GATE      = 10
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     bus_req,
   input logic                     bus_we,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [31:0]              bus_wdata,
   input logic [31:0]              bus_rdata,
   input logic                     bus_ready,
   input logic [NUM_RST-1:0]       periph_rst,
   input logic [GATE_HI-GATE_LO:0] leaf_run,
   input logic                     pci_fast
);

   logic mapped, wr_srst, wr_clk, wr_misc;
   assign mapped  = (bus_addr == ADDR_W'(OFS_STATUS)) || (bus_addr == ADDR_W'(OFS_SRST)) ||
                    (bus_addr == ADDR_W'(OFS_MISC))   || (bus_addr == ADDR_W'(OFS_CLK));
   assign wr_srst = bus_req && bus_we && (bus_addr == ADDR_W'(OFS_SRST));
   assign wr_clk  = bus_req && bus_we && (bus_addr == ADDR_W'(OFS_CLK));
   assign wr_misc = bus_req && bus_we && (bus_addr == ADDR_W'(OFS_MISC));

   a_r2_ready_follows_req: assert property (@(posedge clk) disable iff (rst)
      bus_req |=> bus_ready);

   a_r2_ready_idle: assert property (@(posedge clk) disable iff (rst)
      !bus_req |=> !bus_ready);

   a_r3_pulse_starts: assert property (@(posedge clk) disable iff (rst)
      (wr_srst && bus_wdata[0]) |=> periph_rst[0]);

   a_r4_forced_line: assert property (@(posedge clk) disable iff (rst)
      wr_srst |=> periph_rst[FORCE_RST_BIT]);

   a_r7_gate_stops: assert property (@(posedge clk) disable iff (rst)
      (wr_clk && bus_wdata[GATE_LO]) |=> !leaf_run[0]);

   a_r8_ddr_runs: assert property (@(posedge clk) disable iff (rst)
      leaf_run[DDR_GATE-GATE_LO]);

   a_r10_pci_fast: assert property (@(posedge clk) disable iff (rst)
      (wr_misc && bus_wdata[MS_PCIFAST_BIT]) |=> pci_fast);

   a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
      (bus_req && !bus_we && !mapped) |=> (bus_rdata == '0));

endmodule

bind sysctl_regs sysctl_regs_chk #(
   .ADDR_W        (ADDR_W),
   .NUM_RST       (NUM_RST),
   .FORCE_RST_BIT (FORCE_RST_BIT),
   .GATE_LO       (GATE_LO),
   .GATE_HI       (GATE_HI),
   .DDR_GATE      (DDR_GATE)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bus_req    (bus_req),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .bus_ready  (bus_ready),
   .periph_rst (periph_rst),
   .leaf_run   (leaf_run),
   .pci_fast   (pci_fast)
);

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;

   localparam int CLK_PERIOD = 10;
   localparam int PULSE      = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic        strap_xtal_sel = 1'b0;
   logic [2:0]  strap_ahb_speed = '0;
   logic [1:0]  strap_cpu_ratio = '0;
   logic [31:0] periph_rst;
   logic [12:0] leaf_run;
   logic        pci_clkrun_en;
   logic        sec_clk_full;
   logic [4:0]  tv_half_div;
   logic        pci_fast;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysctl_regs u0 (
      .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .strap_xtal_sel(strap_xtal_sel),
      .strap_ahb_speed(strap_ahb_speed), .strap_cpu_ratio(strap_cpu_ratio),
      .periph_rst(periph_rst), .leaf_run(leaf_run),
      .pci_clkrun_en(pci_clkrun_en), .sec_clk_full(sec_clk_full),
      .tv_half_div(tv_half_div), .pci_fast(pci_fast)
   );

   // behavioural reference state
   int          m_cnt[32];
   logic [31:0] m_clk, m_misc, m_rdata;
   logic        m_ready, m_inrst;
   string       m_rtag;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] m_active();
      logic [31:0] v = '0;
      for (int i = 0; i < 32; i++) v[i] = (m_cnt[i] > 0);
      return v;
   endfunction

   function automatic logic [31:0] m_read(logic [7:0] a);
      case (a)
         8'h04: return (32'(strap_xtal_sel) << 30) | (32'(strap_cpu_ratio) << 18) |
                       (32'(strap_ahb_speed) << 15);
         8'h0C: return m_active();
         8'h30: return m_misc;
         8'h34: return m_clk;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(logic [7:0] a);
      case (a)
         8'h04: return "R11";
         8'h0C: return "R6";
         8'h30: return "R10";
         8'h34: return "R9";
         default: return "R12";
      endcase
   endfunction

   // model of one clock edge using the inputs held across it
   task automatic model_edge();
      logic [31:0] rv;
      if (rst) begin
         for (int i = 0; i < 32; i++) m_cnt[i] = 0;
         m_clk = '0; m_misc = '0; m_rdata = '0; m_ready = 1'b0; m_inrst = 1'b1;
         return;
      end
      m_inrst = 1'b0;
      rv      = m_read(bus_addr);
      m_ready = bus_req;
      m_rdata = (bus_req && !bus_we) ? rv : 32'h0;
      m_rtag  = tag_of(bus_addr);
      for (int i = 0; i < 32; i++) begin
         // R4: line 30 joins every soft-reset write
         if (bus_req && bus_we && bus_addr == 8'h0C && (bus_wdata[i] || i == 30))
            m_cnt[i] = PULSE;
         else if (m_cnt[i] > 0)
            m_cnt[i] = m_cnt[i] - 1;
      end
      // writable clock bits: 1..13 except 10, 16, 24..29
      if (bus_req && bus_we && bus_addr == 8'h34) m_clk  = bus_wdata & 32'h3F01_3BFE;
      if (bus_req && bus_we && bus_addr == 8'h30) m_misc = bus_wdata & 32'h0004_0000;
   endtask

   task automatic compare_all();
      logic [12:0] exp_run;
      for (int k = 0; k < 13; k++) exp_run[k] = ~m_clk[k+1];
      if (m_inrst) begin
         chk("R1 ready",  32'(bus_ready), 32'(m_ready));
         chk("R1 rdata",  bus_rdata, m_rdata);
         chk("R1 resets", periph_rst, 32'h0);
         chk("R1 leaf",   32'(leaf_run), 32'h1FFF);
         chk("R1 fields", {pci_clkrun_en, sec_clk_full, tv_half_div, pci_fast}, 32'h0);
      end else begin
         chk("R2 ready",  32'(bus_ready), 32'(m_ready));
         chk({m_rtag, " rdata"}, bus_rdata, m_rdata);
         chk("R3 resets", periph_rst, m_active());
         chk("R7 leaf",   32'(leaf_run), 32'(exp_run));
         chk("R8 ddr",    32'(leaf_run[9]), 32'h1);
         chk("R9 clkrun", 32'(pci_clkrun_en), 32'(m_clk[16]));
         chk("R9 secsel", 32'(sec_clk_full), 32'(m_clk[29]));
         chk("R9 tvdiv",  32'(tv_half_div), 32'(m_clk[28:24]));
         chk("R10 pci",   32'(pci_fast), 32'(m_misc[18]));
      end
   endtask

   // drive, run one edge, compare at the falling edge
   task automatic step(logic req, logic we, logic [7:0] a, logic [31:0] d);
      bus_req = req; bus_we = we; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 32'h0);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d); step(1'b1, 1'b1, a, d); endtask
   task automatic rd(logic [7:0] a);                 step(1'b1, 1'b0, a, 32'h0); endtask

   initial begin
      int hi;
      @(negedge clk);
      step(1'b0, 1'b0, 8'h00, 32'h0);
      step(1'b1, 1'b1, 8'h34, 32'hFFFF_FFFF);   // R1: write ignored in reset
      step(1'b0, 1'b0, 8'h00, 32'h0);
      rst = 1'b0;
      rd(8'h04); rd(8'h0C); rd(8'h30); rd(8'h34);

      // R7 R8 R9 clock control patterns
      wr(8'h34, 32'hFFFF_FFFF); rd(8'h34);
      wr(8'h34, 32'h2A01_0402); rd(8'h34);
      wr(8'h34, 32'h1500_2AA8); rd(8'h34);
      wr(8'h34, 32'h0000_0000); rd(8'h34);

      // R10 misc
      wr(8'h30, 32'hFFFF_FFFF); rd(8'h30);
      wr(8'h30, 32'h0000_0000); rd(8'h30);

      // R11 status with strap patterns, write ignored
      strap_xtal_sel = 1'b1; strap_ahb_speed = 3'd5; strap_cpu_ratio = 2'd2;
      idle(1);
      wr(8'h04, 32'hFFFF_FFFF); rd(8'h04);
      strap_xtal_sel = 1'b0; strap_ahb_speed = 3'd7; strap_cpu_ratio = 2'd1;
      idle(1);
      rd(8'h04);

      // R3 pulse length on bit 0 and bit 2, R6 readback
      wr(8'h0C, 32'h0000_0005);
      hi = (periph_rst[0] === 1'b1) ? 1 : 0;
      for (int i = 0; i < 20; i++) begin
         if (i == 3) rd(8'h0C); else idle(1);
         if (periph_rst[0] === 1'b1) hi++;
      end
      chk("R3 pulse length", 32'(hi), 32'(PULSE));

      // R4 forced line with zero data
      wr(8'h0C, 32'h0000_0000);
      chk("R4 line30 forced", 32'(periph_rst[30]), 32'h1);
      chk("R4 others quiet",  periph_rst & ~32'h4000_0000, 32'h0);
      idle(PULSE + 2);

      // R5 restart of a running pulse
      wr(8'h0C, 32'h0000_0004);
      idle(10);
      wr(8'h0C, 32'h0000_0004);
      idle(PULSE - 1);
      chk("R5 still high after reload", 32'(periph_rst[2]), 32'h1);
      idle(1);
      chk("R5 low after reloaded pulse", 32'(periph_rst[2]), 32'h0);

      // R12 unmapped addresses
      wr(8'h34, 32'h2000_0100);
      wr(8'h10, 32'hFFFF_FFFF); wr(8'h38, 32'hFFFF_FFFF);
      rd(8'h10); rd(8'h00); rd(8'h35);
      rd(8'h34); rd(8'h30);

      // back-to-back mixed traffic
      wr(8'h0C, 32'h8000_0001); rd(8'h0C); wr(8'h34, 32'h3F00_0002); rd(8'h34);
      rd(8'h04); wr(8'h30, 32'h0004_0000); rd(8'h30);
      idle(PULSE + 2);
      rd(8'h0C);

      // reset in mid-pulse returns to the R1 state
      wr(8'h0C, 32'hFFFF_FFFF);
      rst = 1'b1;
      idle(2);
      rst = 1'b0;
      idle(2);

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule